// File: doc/BRIEF.md
# Descriptor-Ring XOR Parity DMA Engine

The engine is a single DMA channel that computes parity buffers. Software places eight-word descriptors in memory, arranged as a ring. Each descriptor names a destination buffer, up to four source buffers and a length in words. Once the channel is enabled, it reads the descriptor at its current-address register. For every valid descriptor it forms the bitwise XOR of the source buffers and stores the result in the destination. It then marks the descriptor as consumed in memory and moves on to the next descriptor without software help.

A parity matrix with more rows than one descriptor can hold is split over a chain of descriptors that share one destination. The first descriptor of the chain starts a fresh result. Each later descriptor sets its accumulate flag, which folds the destination's existing contents into the XOR. Processing halts on a descriptor that is not marked valid, or after a descriptor carrying the last flag. A descriptor carrying the wrap flag sends the walk back to the ring start address. When the channel halts, it clears its enable bit, drops busy and raises a one-cycle done interrupt. Software can then read where the walk stopped.

Top module: `xor_ring_dma`

## Requirements
- R1: A register write of 1 to bit 0 of register 0 while idle sets the enable bit and raises busy. The first memory request is a read of the address held in register 2 (current descriptor address).
- R2: A descriptor is 32 bytes. Its words 0 to 6 are read in order at ascending addresses, 4 bytes apart. Word 0 holds the flags: valid at bit 0, wrap at bit 1, last at bit 2 and accumulate at bit 3. Word 1 holds the source count (1 to 4) in bits 3:0 and the length in words in bits 31:16. Word 2 holds the destination address. Words 3 to 6 hold the source addresses.
- R3: A descriptor whose word 0 has bit 0 clear ends processing. No memory write is made, and register 2 keeps pointing at that descriptor.
- R4: For every word offset, in ascending order, the destination word receives the XOR of the source words at that offset. It is written once, after all of those reads.
- R5: With the accumulate flag set, the destination word's previous contents are XORed in as well. With it clear, the old destination contents have no effect on the result.
- R6: After the last data write of a descriptor, word 0 is written back to the descriptor's own address with bit 0 cleared and all other bits unchanged.
- R7: After each completed descriptor, register 2 advances by 32. If the wrap flag is set, register 2 is loaded from register 1 (ring start) instead, and the next descriptor is fetched from there.
- R8: A descriptor with the last flag set is the final one processed. Consecutive valid descriptors without it are processed back to back.
- R9: When processing ends, the enable bit and busy are low, and done_irq is high for exactly one clock cycle.
- R10: A memory request, together with its address, direction and write data, is held steady until mem_ready is sampled high.
- R11: Register 0 reads back enable at bit 0 and busy at bit 1, register 1 reads back the ring start and register 2 the current address. Writes to registers 1 and 2 while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 ring start, 2 current address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Channel is walking the ring |
| done_irq | output | 1 | One-cycle pulse when processing ends |

## Verification
The hardest case to reach is a parity chain in which a later descriptor accumulates into a destination that an earlier descriptor of the same run has just written. The expected result then depends on writes the engine itself makes mid-run. The stimulus places such a chain in a single ring, next to a wrap back to the ring start. The bench model keeps a shadow of memory that it updates in descriptor order, so every expected word follows from the writes before it. Memory latency cycles between zero and two wait cycles, so that request holding is exercised on reads and writes alike.

// File: rtl/xrd_pkg.sv
package xrd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_WRITE,
    ST_WBACK
  } xrd_state_e;

  localparam int FLG_VALID  = 0;
  localparam int FLG_WRAP   = 1;
  localparam int FLG_LAST   = 2;
  localparam int FLG_ACC    = 3;
  localparam int DESC_BYTES = 32;
endpackage

// File: rtl/xrd_acc.sv
module xrd_acc #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          first,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] acc
);
  logic [DW-1:0] acc_d;

  always_comb begin
    acc_d = acc;
    if (ld) acc_d = first ? din : (acc ^ din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_d;
  end
endmodule

// File: rtl/xrd_regs.sv
module xrd_regs #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          busy,
  input  logic          stop,
  input  logic          adv,
  input  logic [AW-1:0] adv_addr,
  output logic          start,
  output logic          enable,
  output logic          done_irq,
  output logic [AW-1:0] ring_start,
  output logic [AW-1:0] cur
);
  logic          en_d;
  logic [AW-1:0] ring_d, cur_d;

  assign start = cfg_we && (cfg_addr == 2'd0) && cfg_wdata[0] && !busy;

  always_comb begin
    en_d   = enable;
    ring_d = ring_start;
    cur_d  = cur;
    if (stop)       en_d = 1'b0;
    else if (start) en_d = 1'b1;
    if (cfg_we && (cfg_addr == 2'd1) && !busy) ring_d = cfg_wdata[AW-1:0];
    if (adv) cur_d = adv_addr;
    else if (cfg_we && (cfg_addr == 2'd2) && !busy) cur_d = cfg_wdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable     <= 1'b0;
      done_irq   <= 1'b0;
      ring_start <= '0;
      cur        <= '0;
    end else begin
      enable     <= en_d;
      done_irq   <= stop;
      ring_start <= ring_d;
      cur        <= cur_d;
    end
  end

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = DW'({busy, enable});
      2'd1:    cfg_rdata = DW'(ring_start);
      2'd2:    cfg_rdata = DW'(cur);
      default: cfg_rdata = '0;
    endcase
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  // R9
  done_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!enable && !busy));
  // R11
  ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ring_start));
endmodule

// File: rtl/xrd_ctrl.sv
module xrd_ctrl
  import xrd_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NSRC = 4,
  parameter int CNTW = 4,
  parameter int LENW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] ring_start,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          acc_ld,
  output logic          acc_first,
  input  logic [DW-1:0] acc_val,
  output logic          stop,
  output logic          adv,
  output logic [AW-1:0] adv_addr,
  output logic          busy
);
  localparam int FETCH_WORDS = 3 + NSRC;
  localparam int IDXW = $clog2(FETCH_WORDS + 1);
  localparam int SW   = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int CW   = (CNTW > IDXW) ? CNTW : IDXW;

  xrd_state_e    st_q, st_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [LENW-1:0] off_q, off_d, len_q, len_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [DW-1:0]   w0_q, w0_d;
  logic [AW-1:0]   dst_q, dst_d;
  logic [AW-1:0]   src_q [NSRC];
  logic [AW-1:0]   off_b;
  logic [CW-1:0]   idx_ext, cnt_ext;
  logic            op_dst, op_last;

  assign busy     = (st_q != ST_IDLE);
  assign off_b    = AW'({off_q, 2'b00});
  assign idx_ext  = CW'(idx_q);
  assign cnt_ext  = CW'(cnt_q);
  assign op_dst   = (idx_ext == cnt_ext);
  assign op_last  = w0_q[FLG_ACC] ? op_dst : ((idx_ext + CW'(1)) == cnt_ext);
  assign adv_addr = w0_q[FLG_WRAP] ? ring_start : (cur + AW'(DESC_BYTES));

  always_comb begin
    st_d = st_q; idx_d = idx_q; off_d = off_q; w0_d = w0_q;
    cnt_d = cnt_q; len_d = len_q; dst_d = dst_q;
    stop = 1'b0; adv = 1'b0; acc_ld = 1'b0; acc_first = 1'b0;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    case (st_q)
      ST_IDLE: if (start) begin st_d = ST_FETCH; idx_d = '0; end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur + AW'({idx_q, 2'b00});
        if (mem_ready) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == IDXW'(0)) begin
            w0_d = mem_rdata;
            if (!mem_rdata[FLG_VALID]) begin stop = 1'b1; st_d = ST_IDLE; end
          end
          if (idx_q == IDXW'(1)) begin
            cnt_d = mem_rdata[CNTW-1:0];
            len_d = mem_rdata[16 +: LENW];
          end
          if (idx_q == IDXW'(2)) dst_d = mem_rdata[AW-1:0];
          if (idx_q == IDXW'(FETCH_WORDS - 1)) begin
            idx_d = '0;
            off_d = '0;
            st_d  = (len_q == '0) ? ST_WBACK : ST_READ;
          end
        end
      end
      ST_READ: begin
        mem_req  = 1'b1;
        mem_addr = (op_dst ? dst_q : src_q[idx_q[SW-1:0]]) + off_b;
        if (mem_ready) begin
          acc_ld    = 1'b1;
          acc_first = (idx_q == '0);
          if (op_last) st_d = ST_WRITE;
          else         idx_d = idx_q + 1'b1;
        end
      end
      ST_WRITE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_q + off_b;
        mem_wdata = acc_val;
        if (mem_ready) begin
          idx_d = '0;
          if (off_q == len_q - 1'b1) st_d = ST_WBACK;
          else begin off_d = off_q + 1'b1; st_d = ST_READ; end
        end
      end
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur;
        mem_wdata = w0_q & ~DW'(1);
        if (mem_ready) begin
          adv   = 1'b1;
          idx_d = '0;
          if (w0_q[FLG_LAST]) begin stop = 1'b1; st_d = ST_IDLE; end
          else st_d = ST_FETCH;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= '0; off_q <= '0; w0_q <= '0;
      cnt_q <= '0; len_q <= '0; dst_q <= '0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; off_q <= off_d; w0_q <= w0_d;
      cnt_q <= cnt_d; len_q <= len_d; dst_q <= dst_d;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q[g] <= '0;
      else if ((st_q == ST_FETCH) && mem_ready && (idx_q == IDXW'(3 + g)))
        src_q[g] <= mem_rdata[AW-1:0];
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));
  // R2
  fetch_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_FETCH) && mem_ready && (idx_q != IDXW'(FETCH_WORDS - 1))
     && ((idx_q != '0) || mem_rdata[FLG_VALID]))
    |=> (mem_req && !mem_we && (mem_addr == $past(mem_addr) + AW'(4))));
endmodule

// File: rtl/xor_ring_dma.sv
module xor_ring_dma
  import xrd_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NSRC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          done_irq
);
  logic [1:0]    rst_sync;
  logic          rst_n_s;
  logic          start, stop, adv, enable, acc_ld, acc_first;
  logic [AW-1:0] adv_addr, ring_start, cur;
  logic [DW-1:0] acc_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  xrd_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .stop(stop),
    .adv(adv), .adv_addr(adv_addr), .start(start), .enable(enable),
    .done_irq(done_irq), .ring_start(ring_start), .cur(cur)
  );

  xrd_ctrl #(.AW(AW), .DW(DW), .NSRC(NSRC)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .start(start), .cur(cur), .ring_start(ring_start),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .acc_ld(acc_ld),
    .acc_first(acc_first), .acc_val(acc_val), .stop(stop), .adv(adv),
    .adv_addr(adv_addr), .busy(busy)
  );

  xrd_acc #(.DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n_s), .ld(acc_ld), .first(acc_first),
    .din(mem_rdata), .acc(acc_val)
  );

  // R1
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(busy) |-> (mem_req && !mem_we && (mem_addr == cur) && enable));
  // R7
  cur_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(busy) && !$stable(cur))
    |-> ((cur == $past(cur) + AW'(DESC_BYTES)) || (cur == ring_start)));
endmodule

// File: tb/xor_ring_dma_bench.sv
module xor_ring_dma_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk, rst_n, cfg_we, mem_req, mem_we, mem_ready, busy, done_irq;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata, mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem    [1024];
  logic [31:0] shadow [1024];
  logic [31:0] exp_addr[$];
  logic [31:0] exp_data[$];
  string       exp_tag[$];
  int n_chk = 0, n_fail = 0, wait_cnt = 0, txn = 0;

  xor_ring_dma u_xor_ring_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .done_irq(done_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model and scoreboard monitor, both at the falling edge
  always @(negedge clk) begin
    if (mem_ready) mem_ready <= 1'b0;
    else if (mem_req) begin
      if (wait_cnt >= txn % 3) begin
        wait_cnt  <= 0;
        txn       <= txn + 1;
        mem_ready <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[11:2]] = mem_wdata;
          if (exp_addr.size() == 0)
            chk(1'b0, "R4", "unexpected write", mem_addr, 32'h0);
          else begin
            logic [31:0] ea, ed;
            string t;
            ea = exp_addr.pop_front(); ed = exp_data.pop_front(); t = exp_tag.pop_front();
            chk(mem_addr == ea, t, "write address", mem_addr, ea);
            chk(mem_wdata == ed, t, "write data", mem_wdata, ed);
          end
        end else mem_rdata <= mem[mem_addr[11:2]];
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  task automatic put(input logic [31:0] a, input logic [31:0] v);
    mem[a[11:2]] = v;
    shadow[a[11:2]] = v;
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] v, input string t);
    exp_addr.push_back(a); exp_data.push_back(v); exp_tag.push_back(t);
    shadow[a[11:2]] = v;
  endtask

  // driver: lays out one descriptor (R2 layout) and queues its expected writes
  task automatic desc(input logic [31:0] da, input logic [31:0] w0, input int cnt,
                      input int len, input logic [31:0] dst, input logic [31:0] s0,
                      input logic [31:0] s1, input logic [31:0] s2, input logic [31:0] s3);
    logic [31:0] s[4];
    s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
    put(da, w0);
    put(da + 4, (32'(len) << 16) | 32'(cnt));
    put(da + 8, dst);
    for (int i = 0; i < 4; i++) put(da + 12 + 4 * i, s[i]);
    put(da + 28, 32'h0);
    for (int o = 0; o < len; o++) begin
      logic [31:0] v, da_o;
      da_o = dst + 4 * o;
      v = 32'h0;
      for (int j = 0; j < cnt; j++) v ^= shadow[(s[j] + 4 * o) >> 2];
      if (w0[3]) v ^= shadow[da_o[11:2]];
      push(da_o, v, w0[3] ? "R5" : "R4");
    end
    push(da, w0 & ~32'h1, "R6");
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic wait_done(input string t);
    bit got = 0;
    int n = 0;
    logic [31:0] r;
    while (!got && n < 20000) begin
      @(negedge clk);
      n++;
      if (done_irq) got = 1;
    end
    chk(got, "R9", {t, " done pulse"}, 32'(got), 32'h1);
    @(negedge clk);
    chk(!done_irq && !busy, "R9", {t, " pulse one cycle, busy low"},
        {30'h0, done_irq, busy}, 32'h0);
    cfg_read(2'd0, r);
    chk(r == 32'h0, "R9", {t, " enable cleared"}, r, 32'h0);
    chk(exp_addr.size() == 0, "R4", {t, " all writes seen"}, 32'(exp_addr.size()), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    chk(1'b0, "R9", "watchdog expired", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
      shadow[i] = mem[i];
    end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = 32'h0;
    mem_ready = 1'b0; mem_rdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk(!busy && !done_irq && !mem_req, "R9", "reset outputs idle",
        {29'h0, busy, done_irq, mem_req}, 32'h0);
    cfg_read(2'd0, r);
    chk(r == 32'h0, "R11", "reset control reg", r, 32'h0);

    // ring of three: fresh two-source, accumulating chain, four-source last
    desc(32'h000, 32'h0000_0001, 2, 3, 32'h800, 32'h400, 32'h440, 0, 0);
    desc(32'h020, 32'h0000_0009, 1, 3, 32'h800, 32'h480, 0, 0, 0);
    desc(32'h040, 32'hF0F0_0005, 4, 2, 32'h900, 32'h400, 32'h440, 32'h480, 32'h4C0);
    cfg_write(2'd1, 32'h0);
    cfg_write(2'd2, 32'h0);
    cfg_read(2'd2, r);
    chk(r == 32'h0, "R11", "current address readback", r, 32'h0);
    cfg_write(2'd0, 32'h1);
    cfg_read(2'd0, r);
    chk(r == 32'h3, "R1", "enable and busy after start", r, 32'h3);
    cfg_write(2'd2, 32'hABC);
    cfg_write(2'd1, 32'h7F0);
    wait_done("R8 chain");
    cfg_read(2'd2, r);
    chk(r == 32'h060, "R7", "advance by 32 per descriptor", r, 32'h060);
    cfg_read(2'd1, r);
    chk(r == 32'h0, "R11", "ring start write ignored while busy", r, 32'h0);
    chk(mem[0] == 32'h0, "R6", "valid cleared in memory", mem[0], 32'h0);
    chk(mem[16] == 32'hF0F0_0004, "R6", "other flag bits kept", mem[16], 32'hF0F0_0004);

    // invalid descriptor at the current address
    put(32'h060, 32'hFFFF_FFFE);
    cfg_write(2'd0, 32'h1);
    wait_done("R3 invalid");
    cfg_read(2'd2, r);
    chk(r == 32'h060, "R3", "address stays on invalid descriptor", r, 32'h060);
    chk(mem[24] == 32'hFFFF_FFFE, "R3", "invalid descriptor untouched", mem[24], 32'hFFFF_FFFE);

    // wrap back to ring start, then a last descriptor there
    desc(32'h260, 32'h0000_0003, 3, 1, 32'hA00, 32'h500, 32'h540, 32'h580, 0);
    desc(32'h200, 32'h0000_000D, 1, 2, 32'hA00, 32'h5C0, 0, 0, 0);
    cfg_write(2'd1, 32'h200);
    cfg_write(2'd2, 32'h260);
    cfg_write(2'd0, 32'h1);
    wait_done("R7 wrap");
    cfg_read(2'd2, r);
    chk(r == 32'h220, "R7", "wrap reloads ring start", r, 32'h220);

    // valid descriptor followed by an invalid one
    desc(32'h300, 32'h0000_0001, 1, 1, 32'hB00, 32'h600, 0, 0, 0);
    put(32'h320, 32'h0000_000E);
    cfg_write(2'd2, 32'h300);
    cfg_write(2'd0, 32'h1);
    wait_done("R3 stop after valid");
    cfg_read(2'd2, r);
    chk(r == 32'h320, "R3", "stops at following invalid descriptor", r, 32'h320);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule